// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block takes an asynchronous serial line that idles high and recovers bytes from it. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The block does not generate its own timing. Another block supplies a single-clock tick at eight times the baud rate; at 115200 baud that is 921600 ticks per second. All line sampling and bit timing advance only on that tick.

The raw line first passes a two-stage synchronizer, which shifts only on ticks. It then passes a saturating-counter glitch filter. A falling edge on the filtered line wakes the frame sequencer. The sequencer re-checks the start bit half a bit later and then samples every following bit one bit period apart. Data bits move into a shift register whose contents appear on the data port while the frame is still arriving. When the stop bit is sampled high, a one-clock valid pulse marks the byte; the data port is only guaranteed to hold the complete byte on that clock.

Top module: `os_byte_rx`

## Requirements
- R1: A frame made of a low start bit, eight data bits (bit 0 first) and a high stop bit, each held for 8 ticks, is received as that byte on `byte_out`. Every byte value 0x00 to 0xFF is recovered correctly.
- R2: `byte_valid` stays high for exactly one clock per accepted frame, and `byte_out` holds the complete byte during that clock.
- R3: The synchronizer and the filter change state only on clocks where `os_tick` is high. A line pulse of any length that begins and ends while `os_tick` is held low produces no frame and leaves `byte_out` unchanged.
- R4: The filter uses a 2-bit counter that moves toward 3 while the synchronized line is 1 and toward 0 while it is 0. The filtered line falls only at count 0 and rises only at count 3. A low pulse lasting 1 or 2 ticks on an idle line therefore starts no frame.
- R5: After a falling edge of the filtered line, the start bit is sampled again 4 ticks later. If the filtered line is high at that point, the sequencer returns to idle, produces no valid pulse and leaves `byte_out` unchanged. A 3-tick low pulse is rejected this way.
- R6: Each sampled data bit enters `byte_out` at bit 7 while the earlier bits move one place toward bit 0, so a partly received byte is visible. Example: after 0x00 has been received, once the seven data bits 0 to 6 of a 0xFF frame have been sampled, `byte_out` reads 0xFE.
- R7: If the filtered line is low when the stop bit is sampled, no valid pulse is produced and the frame is discarded.
- R8: After the stop bit the sequencer waits for a new falling edge of the filtered line. A line held low after a bad stop bit starts no frame until it returns high and falls again; the next proper frame is then received correctly.
- R9: After reset, `byte_out` is 0x00, `byte_valid` is 0, and the line is treated as idle high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Single-clock strobe at 8 times the baud rate |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| byte_out | output | 8 | Received byte, also showing partial bytes during reception |
| byte_valid | output | 1 | One-clock pulse when a frame with a good stop bit completes |

## Verification
The embedded assertions check on every cycle that:
- the synchronizer and the filtered line hold still between ticks;
- the valid pulse never lasts two clocks and only follows a high stop-bit sample;
- the data register moves only on a bit strobe;
- the sequencer leaves idle only on a tick.

Only the bench scenarios can show the following:
- correct recovery of all 256 byte values;
- the rejection of 1-, 2- and 3-tick low spikes;
- the partial byte pattern in the middle of a frame;
- the discarded frame with a low stop bit and the re-arming that follows it.

These depend on the timing of the whole path from line to data.

// File: rtl/os_rx_pkg.sv
package os_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_W   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_in,
  output logic line_f
);
  localparam logic [FILT_W-1:0] FMAX = '1;
  localparam logic [FILT_W-1:0] FMIN = '0;

  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_W-1:0]   fcnt;
  logic                filt_q;
  logic                sync_msb;

  assign sync_msb = sync_q[SYNC_LEN-1];
  assign line_f   = filt_q;

  // synchronizer chain, shifts only on oversample ticks
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
    end else if (tick) begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_in};
    end
  end

  // saturating up/down glitch filter with hysteresis at the extremes
  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt   <= FMAX;
      filt_q <= 1'b1;
    end else if (tick) begin
      if (sync_msb && fcnt != FMAX)
        fcnt <= fcnt + 1'b1;
      else if (!sync_msb && fcnt != FMIN)
        fcnt <= fcnt - 1'b1;
      if (fcnt == FMAX)
        filt_q <= 1'b1;
      else if (fcnt == FMIN)
        filt_q <= 1'b0;
    end
  end

  // R3: nothing in the conditioner moves without a tick
  a_r3_sync_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sync_q));
  a_r3_filter_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(line_f));
  // R4: the filtered line only falls after the counter has emptied
  a_r4_fall_needs_empty: assert property (@(posedge clk) disable iff (rst)
    (tick && line_f && fcnt != FMIN) |=> line_f);
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  output logic next_bit
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] HALF = CW'(OSR / 2);

  logic [CW-1:0] pos_q;

  // restart loads the half-bit offset so the first strobe lands mid start bit
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (restart) begin
      pos_q <= HALF;
    end else if (tick) begin
      if (pos_q == LAST)
        pos_q <= '0;
      else
        pos_q <= pos_q + 1'b1;
    end
  end

  assign next_bit = tick && (pos_q == LAST) && !restart;

  // R5: the strobe never fires on the clock right after a restart
  a_r5_no_early_strobe: assert property (@(posedge clk) disable iff (rst)
    restart |=> !next_bit);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import os_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line_f,
  input  logic              next_bit,
  output logic              restart,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic              filt_d;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              valid_q;

  assign restart = tick && (state_q == ST_IDLE) && filt_d && !line_f;
  assign data_o  = shreg_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      filt_d  <= 1'b1;
      idx_q   <= '0;
      shreg_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (tick) filt_d <= line_f;
      case (state_q)
        ST_IDLE: begin
          if (restart) state_q <= ST_START;
        end
        ST_START: begin
          if (next_bit) begin
            idx_q   <= '0;
            state_q <= line_f ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (next_bit) begin
            shreg_q <= {line_f, shreg_q[DATA_W-1:1]};
            idx_q   <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (next_bit) begin
            valid_q <= line_f;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a valid pulse lasts one clock
  a_r2_one_clock_valid: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  // R7: a valid pulse follows a high filtered line at the stop sample
  a_r7_valid_needs_stop_high: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $past(line_f));
  // R6: the data register only moves on a bit strobe
  a_r6_data_moves_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !next_bit |=> $stable(shreg_q));
  // R8: idle is left only on an oversample tick
  a_r8_idle_until_tick: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !tick) |=> state_q == ST_IDLE);
endmodule

// File: rtl/os_byte_rx.sv
module os_byte_rx #(
  parameter int DATA_W   = 8,
  parameter int OSR      = 8,
  parameter int SYNC_LEN = 2,
  parameter int FILT_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              serial_in,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_valid
);
  logic line_f;
  logic restart;
  logic next_bit;

  rx_line_cond #(
    .SYNC_LEN (SYNC_LEN),
    .FILT_W   (FILT_W)
  ) u_cond (
    .clk     (clk),
    .rst     (rst),
    .tick    (os_tick),
    .line_in (serial_in),
    .line_f  (line_f)
  );

  rx_bit_timer #(
    .OSR (OSR)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (os_tick),
    .restart  (restart),
    .next_bit (next_bit)
  );

  rx_frame_fsm #(
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (os_tick),
    .line_f   (line_f),
    .next_bit (next_bit),
    .restart  (restart),
    .data_o   (byte_out),
    .valid_o  (byte_valid)
  );
endmodule

// File: tb/os_byte_rx_bench.sv
module os_byte_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       tick_en = 1'b0;
  logic       serial_in = 1'b1;
  logic [7:0] byte_out;
  logic       byte_valid;

  int total = 0;
  int bad = 0;
  int rdy_cnt = 0;
  int dbl_cnt = 0;
  logic [7:0] last_byte = 8'h00;
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  os_byte_rx u_os_byte_rx (
    .clk        (clk),
    .rst        (rst),
    .os_tick    (os_tick),
    .serial_in  (serial_in),
    .byte_out   (byte_out),
    .byte_valid (byte_valid)
  );

  always #5 clk = ~clk;

  // tick every second clock while enabled
  initial begin
    forever begin
      @(negedge clk);
      os_tick = tick_en && !os_tick;
    end
  end

  // valid pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (byte_valid) begin
        rdy_cnt++;
        last_byte = byte_out;
        if (prev_valid) dbl_cnt++;
      end
      prev_valid = byte_valid;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    serial_in = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] v, input logic stop_b);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(v[i]);
    drive_bit(stop_b);
  endtask

  task automatic good_byte(input logic [7:0] v, input string tag);
    int n0;
    n0 = rdy_cnt;
    send_frame(v, 1'b1);
    drive_bit(1'b1);
    drive_bit(1'b1);
    check(rdy_cnt == n0 + 1, tag, rdy_cnt - n0, 1);
    check(last_byte == v, tag, last_byte, v);
  endtask

  initial begin
    int n0;
    logic [7:0] keep;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick_en = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(byte_out == 8'h00, "R9 data after reset", byte_out, 0);
    check(byte_valid == 1'b0, "R9 valid after reset", byte_valid, 0);
    drive_bit(1'b1);
    drive_bit(1'b1);

    // R1 sweep of every byte value
    for (int v = 0; v < 256; v++) good_byte(8'(v), "R1 byte sweep");

    // R6 partial byte visible mid frame
    good_byte(8'h00, "R6 preamble byte");
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(1'b1);
    check(byte_out == 8'hFE, "R6 partial byte", byte_out, 8'hFE);
    drive_bit(1'b1);
    drive_bit(1'b1);
    drive_bit(1'b1);
    check(last_byte == 8'hFF, "R6 completed byte", last_byte, 8'hFF);

    // R7 bad stop bit, then R8 line held low before re-arming
    n0 = rdy_cnt;
    send_frame(8'hA5, 1'b0);
    repeat (3) drive_bit(1'b0);
    repeat (3) drive_bit(1'b1);
    check(rdy_cnt == n0, "R7 bad stop discarded", rdy_cnt - n0, 0);
    good_byte(8'h3C, "R8 byte after low hold");

    // R4 short glitches on idle line
    keep = byte_out;
    n0 = rdy_cnt;
    serial_in = 1'b0;
    repeat (2) @(negedge clk);
    serial_in = 1'b1;
    repeat (6) drive_bit(1'b1);
    serial_in = 1'b0;
    repeat (4) @(negedge clk);
    serial_in = 1'b1;
    repeat (6) drive_bit(1'b1);
    check(rdy_cnt == n0, "R4 glitch ignored", rdy_cnt - n0, 0);
    check(byte_out == keep, "R4 data kept", byte_out, keep);
    good_byte(8'h5A, "R4 byte after glitch");

    // R5 three-tick pulse passes filter but fails start check
    keep = byte_out;
    n0 = rdy_cnt;
    serial_in = 1'b0;
    repeat (6) @(negedge clk);
    serial_in = 1'b1;
    repeat (12) drive_bit(1'b1);
    check(rdy_cnt == n0, "R5 false start", rdy_cnt - n0, 0);
    check(byte_out == keep, "R5 data kept", byte_out, keep);
    good_byte(8'hC4, "R5 byte after false start");

    // R3 line activity without ticks is not seen
    keep = byte_out;
    n0 = rdy_cnt;
    tick_en = 1'b0;
    repeat (4) @(negedge clk);
    serial_in = 1'b0;
    repeat (200) @(negedge clk);
    serial_in = 1'b1;
    repeat (20) @(negedge clk);
    tick_en = 1'b1;
    repeat (12) drive_bit(1'b1);
    check(rdy_cnt == n0, "R3 no tick no frame", rdy_cnt - n0, 0);
    check(byte_out == keep, "R3 data kept", byte_out, keep);
    good_byte(8'h81, "R3 byte after pause");

    // R2 every valid pulse was a single clock
    check(dbl_cnt == 0, "R2 single clock valid", dbl_cnt, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule